// File: doc/BRIEF.md
# Address Translation Sequencer with Fault Encoding

This block sits in front of the page-table walker of a 32-bit segmented memory-management unit. For each access it decides which translation path applies and reports the outcome. The paths, in falling priority, are: untranslated (real-mode) access, a granted hit from the block-translation matcher, a direct-store segment, a segment no-execute violation, and a hashed page walk. A page walk is handed to an external walker. Every other path finishes inside the block. Sixteen segment registers are held locally. The top four bits of the effective address select one of them, and software loads them through a simple write port.

Each finished access gives a single-cycle `done_o` pulse. With it come a success flag, the real address on success, and on failure an exception class, a 32-bit syndrome word and the faulting effective address. The syndrome depends both on the access kind (load, store or fetch) and on the instruction class (integer, floating-point, reservation, cache-management or external-control). The block-translation matcher reports on `blk_grant` and `blk_raddr` in the same cycle as the request. The walker is started by `walk_start_o` and answers with `walk_done` and a status code.

Top module: `xlat_seq_top`

## Requirements
- R1: Translation is off for a fetch (`req_kind`=2) when `irelo_en`=0, and for a load (0) or store (1) when `drelo_en`=0. Such an access completes with `done_o` one cycle after the request, `ok_o`=1 and `raddr_o` equal to `req_ea`, whatever the segment holds.
- R2: With translation on, `blk_grant`=1 completes the access one cycle later with `ok_o`=1 and `raddr_o`=`blk_raddr`. It takes priority over every segment path.
- R3: Segment register `n` is written by `seg_we` with `seg_idx`=`n`. The register used by a request is the one selected by `req_ea[31:28]`. Segment fields: bit 31 direct-store flag T, bit 30 supervisor key, bit 29 user key (the key in use is bit 29 when `priv_user`=1, else bit 30), bit 28 no-execute (for T=0), bits 28:20 bus-unit ID (for T=1).
- R4: In a direct-store segment whose bus-unit ID is 0x07F, every access succeeds, including fetches and every class, with `raddr_o` = {segment bits 3:0, `req_ea[27:0]`}.
- R5: In any other direct-store segment, the outcome depends on the access. A fetch gives class 1 with syndrome 0x10000000. Class 1 (floating-point) gives class 3 (alignment) with syndrome 0. Class 2 (reservation) gives class 2 with 0x04000000 on a load or 0x06000000 on a store. Class 4 (external-control) gives class 2 with 0x04100000 on a load or 0x06100000 on a store. Class 3 (cache-management) succeeds with `raddr_o`=`req_ea`.
- R6: In such a segment, classes 0, 5, 6 and 7 are integer accesses. A load succeeds only when the key in use is 0 and a store only when it is 1, with `raddr_o`=`req_ea`. Otherwise the access gives class 2 with syndrome 0x08000000 on a load or 0x0A000000 on a store.
- R7: A fetch from a segment with T=0 and no-execute set gives class 1 with syndrome 0x10000000 and starts no walk. Loads and stores in that segment walk normally.
- R8: Any other translated access raises `walk_start_o` for one cycle, one cycle after the request. It presents the effective address on `walk_ea_o` and the selected segment on `walk_seg_o`. `done_o` follows one cycle after `walk_done`, and it never coincides with `walk_start_o`.
- R9: Walk status 1 (not found) gives class 1 with 0x40000000 on a fetch, and class 2 with 0x40000000 on a load or 0x42000000 on a store. Walk status 0 succeeds with `raddr_o`=`walk_raddr`.
- R10: Walk status 2 or 3 (protection) gives class 1 with 0x08000000 on a fetch, and class 2 with 0x08000000 on a load or 0x0A000000 on a store.
- R11: Exception class encoding is 0 none, 1 instruction storage, 2 data storage, 3 alignment. On success the class, syndrome and `fault_addr_o` are 0. On any fault `fault_addr_o` equals the request's effective address and `raddr_o` is 0.
- R12: While a walk is pending, `req_valid` is ignored. No `done_o` appears until `walk_done`, and the pending access's result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_idx | input | 4 | Segment register written |
| seg_wdata | input | 32 | Segment register write value |
| req_valid | input | 1 | Access request |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_iclass | input | 3 | Instruction class |
| priv_user | input | 1 | Access made in user (problem) state |
| irelo_en | input | 1 | Instruction translation enable |
| drelo_en | input | 1 | Data translation enable |
| blk_grant | input | 1 | Block-translation hit that grants the access |
| blk_raddr | input | 32 | Real address from the block-translation matcher |
| walk_start_o | output | 1 | Start pulse to the page walker |
| walk_ea_o | output | 32 | Effective address handed to the walker |
| walk_seg_o | output | 32 | Segment register handed to the walker |
| walk_done | input | 1 | Walker finished |
| walk_status | input | 2 | 0 ok, 1 not found, 2/3 protection |
| walk_raddr | input | 32 | Real address from the walker |
| done_o | output | 1 | Result valid pulse |
| ok_o | output | 1 | Access granted |
| raddr_o | output | 32 | Real address |
| exc_o | output | 2 | Exception class |
| syndrome_o | output | 32 | Fault syndrome word |
| fault_addr_o | output | 32 | Faulting effective address |

## Verification
Two functions can meet in one cycle. One is a fresh request arriving on `req_valid`. The other is a walk result arriving on `walk_done`, or a pending walk blocking the request path. The bench provokes the clash on every walked access: one cycle after `walk_start_o`, it drives a real-mode request that would complete at once if accepted. It then judges that `done_o` stays low, and that the later result carries the walked access's address, kind and syndrome rather than the intruder's. The sweep also crosses `blk_grant` against every segment type, kind, class and privilege, so that the priority between the block hit and the direct-store and no-execute paths is judged for every combination.

// File: rtl/xlat_pkg.sv
// Shared encodings for the translation sequencer.
// Assumes a 32-bit effective address and 32-bit segment registers.
package xlat_pkg;
    localparam int ADDR_W = 32;
    localparam int SEG_W  = 32;

    // Segment register field positions
    localparam int SEG_T_BIT   = 31;
    localparam int SEG_KS_BIT  = 30;
    localparam int SEG_KU_BIT  = 29;
    localparam int SEG_NX_BIT  = 28;
    localparam int SEG_BUID_HI = 28;
    localparam int SEG_BUID_LO = 20;
    localparam logic [8:0] BUID_MEMFORCE = 9'h07F;

    // Access kinds
    localparam logic [1:0] KIND_LOAD  = 2'd0;
    localparam logic [1:0] KIND_STORE = 2'd1;
    localparam logic [1:0] KIND_FETCH = 2'd2;

    // Instruction classes
    localparam logic [2:0] CLS_INT   = 3'd0;
    localparam logic [2:0] CLS_FLOAT = 3'd1;
    localparam logic [2:0] CLS_RESV  = 3'd2;
    localparam logic [2:0] CLS_CACHE = 3'd3;
    localparam logic [2:0] CLS_EXTC  = 3'd4;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_ISTOR = 2'd1,
        EXC_DSTOR = 2'd2,
        EXC_ALIGN = 2'd3
    } exc_e;

    typedef enum logic [3:0] {
        OC_OK,
        OC_NOTFOUND,
        OC_PROT,
        OC_NOEXEC,
        OC_DS_FETCH,
        OC_DS_FLOAT,
        OC_DS_RESV,
        OC_DS_EXTC,
        OC_WALK
    } outcome_e;
endpackage

// File: rtl/xlat_segfile.sv
// Bank of NSEG segment registers with one write port and one read port.
// Assumes the read returns the value held before a same-cycle write.
module xlat_segfile #(
    parameter int NSEG = 16,
    parameter int W    = 32,
    localparam int IDX_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] regs [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        // Hold one segment register, loaded when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && wr_idx == IDX_W'(g))
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/xlat_decide.sv
// Combinational path selection for one request: real mode, block hit,
// direct-store segment, segment no-execute, or page walk.
// Assumes blk_grant is valid in the request cycle.
module xlat_decide
    import xlat_pkg::*;
(
    input  logic [ADDR_W-1:0] ea,
    input  logic [1:0]        kind,
    input  logic [2:0]        iclass,
    input  logic              priv_user,
    input  logic              irelo_en,
    input  logic              drelo_en,
    input  logic              blk_grant,
    input  logic [ADDR_W-1:0] blk_raddr,
    input  logic [SEG_W-1:0]  seg,
    output outcome_e          oc,
    output logic [ADDR_W-1:0] raddr
);
    logic is_fetch, is_store, xlat_on, key;
    logic unused_seg_bits;

    assign is_fetch = (kind == KIND_FETCH);
    assign is_store = (kind == KIND_STORE);
    assign xlat_on  = is_fetch ? irelo_en : drelo_en;
    assign key      = priv_user ? seg[SEG_KU_BIT] : seg[SEG_KS_BIT];
    assign unused_seg_bits = ^seg[19:4];

    // Walk the fixed priority order and pick one outcome
    always_comb begin
        oc    = OC_OK;
        raddr = ea;
        if (!xlat_on) begin
            oc = OC_OK;
        end else if (blk_grant) begin
            raddr = blk_raddr;
        end else if (seg[SEG_T_BIT]) begin
            if (seg[SEG_BUID_HI:SEG_BUID_LO] == BUID_MEMFORCE) begin
                raddr = {seg[3:0], ea[27:0]};
            end else if (is_fetch) begin
                oc = OC_DS_FETCH;
            end else begin
                case (iclass)
                    CLS_FLOAT: oc = OC_DS_FLOAT;
                    CLS_RESV:  oc = OC_DS_RESV;
                    CLS_EXTC:  oc = OC_DS_EXTC;
                    CLS_CACHE: oc = OC_OK;
                    default:   oc = (is_store ? !key : key) ? OC_PROT : OC_OK;
                endcase
            end
        end else if (is_fetch && seg[SEG_NX_BIT]) begin
            oc = OC_NOEXEC;
        end else begin
            oc = OC_WALK;
        end
    end
endmodule

// File: rtl/xlat_fault_enc.sv
// Maps a final outcome plus access kind to exception class and syndrome.
// Assumes OC_WALK never reaches it as a final outcome.
module xlat_fault_enc
    import xlat_pkg::*;
(
    input  outcome_e    oc,
    input  logic        is_fetch,
    input  logic        is_store,
    output exc_e        exc,
    output logic [31:0] syndrome
);
    logic [31:0] st_bit;
    assign st_bit = is_store ? 32'h0200_0000 : 32'h0;

    // Choose the exception class and syndrome word for the outcome
    always_comb begin
        exc      = EXC_NONE;
        syndrome = '0;
        case (oc)
            OC_NOTFOUND: begin
                exc      = is_fetch ? EXC_ISTOR : EXC_DSTOR;
                syndrome = 32'h4000_0000 | (is_fetch ? 32'h0 : st_bit);
            end
            OC_PROT: begin
                exc      = is_fetch ? EXC_ISTOR : EXC_DSTOR;
                syndrome = 32'h0800_0000 | (is_fetch ? 32'h0 : st_bit);
            end
            OC_NOEXEC, OC_DS_FETCH: begin
                exc      = EXC_ISTOR;
                syndrome = 32'h1000_0000;
            end
            OC_DS_FLOAT: begin
                exc = EXC_ALIGN;
            end
            OC_DS_RESV: begin
                exc      = EXC_DSTOR;
                syndrome = 32'h0400_0000 | st_bit;
            end
            OC_DS_EXTC: begin
                exc      = EXC_DSTOR;
                syndrome = 32'h0410_0000 | st_bit;
            end
            default: begin
                exc      = EXC_NONE;
                syndrome = '0;
            end
        endcase
    end
endmodule

// File: rtl/xlat_seq_top.sv
// Translation sequencer: accepts one access, resolves it locally or via
// the external page walker, and registers the result with a done pulse.
// Assumes the walker answers once per walk_start_o; requests are ignored
// while a walk is pending.
module xlat_seq_top
    import xlat_pkg::*;
#(
    parameter int NSEG = 16,
    localparam int IDX_W = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_we,
    input  logic [IDX_W-1:0]  seg_idx,
    input  logic [SEG_W-1:0]  seg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic [1:0]        req_kind,
    input  logic [2:0]        req_iclass,
    input  logic              priv_user,
    input  logic              irelo_en,
    input  logic              drelo_en,
    input  logic              blk_grant,
    input  logic [ADDR_W-1:0] blk_raddr,
    output logic              walk_start_o,
    output logic [ADDR_W-1:0] walk_ea_o,
    output logic [SEG_W-1:0]  walk_seg_o,
    input  logic              walk_done,
    input  logic [1:0]        walk_status,
    input  logic [ADDR_W-1:0] walk_raddr,
    output logic              done_o,
    output logic              ok_o,
    output logic [ADDR_W-1:0] raddr_o,
    output logic [1:0]        exc_o,
    output logic [31:0]       syndrome_o,
    output logic [ADDR_W-1:0] fault_addr_o
);
    logic [SEG_W-1:0]  seg_rd;
    outcome_e          dec_oc, walk_oc, sel_oc;
    logic [ADDR_W-1:0] dec_raddr, sel_raddr, sel_ea;
    logic              sel_fetch, sel_store;
    exc_e              enc_exc;
    logic [31:0]       enc_syn;

    logic              busy_q, done_q, ws_q, ok_q;
    logic              pend_fetch, pend_store;
    logic [ADDR_W-1:0] pend_ea, raddr_q, fault_q;
    logic [SEG_W-1:0]  wseg_q;
    exc_e              exc_q;
    logic [31:0]       syn_q;

    xlat_segfile #(.NSEG(NSEG), .W(SEG_W)) u_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (seg_we),
        .wr_idx  (seg_idx),
        .wr_data (seg_wdata),
        .rd_idx  (req_ea[ADDR_W-1 -: IDX_W]),
        .rd_data (seg_rd)
    );

    xlat_decide u_dec (
        .ea        (req_ea),
        .kind      (req_kind),
        .iclass    (req_iclass),
        .priv_user (priv_user),
        .irelo_en  (irelo_en),
        .drelo_en  (drelo_en),
        .blk_grant (blk_grant),
        .blk_raddr (blk_raddr),
        .seg       (seg_rd),
        .oc        (dec_oc),
        .raddr     (dec_raddr)
    );

    // Translate the walker status code into an outcome
    always_comb begin
        case (walk_status)
            2'd0:    walk_oc = OC_OK;
            2'd1:    walk_oc = OC_NOTFOUND;
            default: walk_oc = OC_PROT;
        endcase
    end

    // Select the source of the result: pending walk or fresh request
    always_comb begin
        sel_oc    = busy_q ? walk_oc    : dec_oc;
        sel_raddr = busy_q ? walk_raddr : dec_raddr;
        sel_ea    = busy_q ? pend_ea    : req_ea;
        sel_fetch = busy_q ? pend_fetch : (req_kind == KIND_FETCH);
        sel_store = busy_q ? pend_store : (req_kind == KIND_STORE);
    end

    xlat_fault_enc u_enc (
        .oc       (sel_oc),
        .is_fetch (sel_fetch),
        .is_store (sel_store),
        .exc      (enc_exc),
        .syndrome (enc_syn)
    );

    // Sequence: accept, start a walk or finish, then wait for the walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            ws_q       <= 1'b0;
            ok_q       <= 1'b0;
            pend_fetch <= 1'b0;
            pend_store <= 1'b0;
            pend_ea    <= '0;
            wseg_q     <= '0;
            raddr_q    <= '0;
            fault_q    <= '0;
            exc_q      <= EXC_NONE;
            syn_q      <= '0;
        end else begin
            done_q <= 1'b0;
            ws_q   <= 1'b0;
            if (!busy_q && req_valid) begin
                pend_ea    <= req_ea;
                pend_fetch <= (req_kind == KIND_FETCH);
                pend_store <= (req_kind == KIND_STORE);
                if (dec_oc == OC_WALK) begin
                    busy_q <= 1'b1;
                    ws_q   <= 1'b1;
                    wseg_q <= seg_rd;
                end else begin
                    done_q <= 1'b1;
                end
            end else if (busy_q && walk_done) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
            if ((!busy_q && req_valid && dec_oc != OC_WALK) || (busy_q && walk_done)) begin
                ok_q    <= (enc_exc == EXC_NONE);
                exc_q   <= enc_exc;
                syn_q   <= enc_syn;
                raddr_q <= (enc_exc == EXC_NONE) ? sel_raddr : '0;
                fault_q <= (enc_exc == EXC_NONE) ? '0 : sel_ea;
            end
        end
    end

    assign walk_start_o = ws_q;
    assign walk_ea_o    = pend_ea;
    assign walk_seg_o   = wseg_q;
    assign done_o       = done_q;
    assign ok_o         = ok_q;
    assign raddr_o      = raddr_q;
    assign exc_o        = exc_q;
    assign syndrome_o   = syn_q;
    assign fault_addr_o = fault_q;
endmodule

// File: rtl/xlat_seq_chk.sv
// Property checker for xlat_seq_top, attached by bind below.
// Assumes the top's internal busy_q flag marks a pending walk.
module xlat_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_ea,
    input logic [1:0]  req_kind,
    input logic        irelo_en,
    input logic        drelo_en,
    input logic        blk_grant,
    input logic [31:0] blk_raddr,
    input logic        busy_q,
    input logic        walk_done,
    input logic        walk_start_o,
    input logic        done_o,
    input logic        ok_o,
    input logic [31:0] raddr_o,
    input logic [1:0]  exc_o,
    input logic [31:0] syndrome_o,
    input logic [31:0] fault_addr_o
);
    logic relo_on;
    assign relo_on = (req_kind == 2'd2) ? irelo_en : drelo_en;

    assert_real_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy_q && !relo_on |=> done_o && ok_o && raddr_o == $past(req_ea));

    assert_blk_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy_q && relo_on && blk_grant |=> done_o && ok_o && raddr_o == $past(blk_raddr));

    assert_align_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && exc_o == 2'd3 |-> syndrome_o == 32'h0 && !ok_o);

    assert_walk_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && walk_start_o));

    assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(req_valid) || $past(walk_done));

    assert_ok_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && ok_o |-> exc_o == 2'd0 && syndrome_o == 32'h0 && fault_addr_o == 32'h0);

    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !walk_done |=> !done_o);
endmodule

bind xlat_seq_top xlat_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ea       (req_ea),
    .req_kind     (req_kind),
    .irelo_en     (irelo_en),
    .drelo_en     (drelo_en),
    .blk_grant    (blk_grant),
    .blk_raddr    (blk_raddr),
    .busy_q       (busy_q),
    .walk_done    (walk_done),
    .walk_start_o (walk_start_o),
    .done_o       (done_o),
    .ok_o         (ok_o),
    .raddr_o      (raddr_o),
    .exc_o        (exc_o),
    .syndrome_o   (syndrome_o),
    .fault_addr_o (fault_addr_o)
);

// File: tb/xlat_seq_top_tb.sv
module xlat_seq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [3:0]  seg_idx = '0;
    logic [31:0] seg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_iclass = '0;
    logic        priv_user = 1'b0;
    logic        irelo_en = 1'b0;
    logic        drelo_en = 1'b0;
    logic        blk_grant = 1'b0;
    logic [31:0] blk_raddr = '0;
    logic        walk_start_o;
    logic [31:0] walk_ea_o;
    logic [31:0] walk_seg_o;
    logic        walk_done = 1'b0;
    logic [1:0]  walk_status = '0;
    logic [31:0] walk_raddr = '0;
    logic        done_o, ok_o;
    logic [31:0] raddr_o;
    logic [1:0]  exc_o;
    logic [31:0] syndrome_o, fault_addr_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] segs [16];

    always #2 clk = ~clk;

    xlat_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_idx(seg_idx), .seg_wdata(seg_wdata),
        .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind), .req_iclass(req_iclass),
        .priv_user(priv_user), .irelo_en(irelo_en), .drelo_en(drelo_en),
        .blk_grant(blk_grant), .blk_raddr(blk_raddr),
        .walk_start_o(walk_start_o), .walk_ea_o(walk_ea_o), .walk_seg_o(walk_seg_o),
        .walk_done(walk_done), .walk_status(walk_status), .walk_raddr(walk_raddr),
        .done_o(done_o), .ok_o(ok_o), .raddr_o(raddr_o), .exc_o(exc_o),
        .syndrome_o(syndrome_o), .fault_addr_o(fault_addr_o)
    );

    task automatic check(input bit cond, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!cond) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Result vector: {done, ok, exc, syndrome, raddr, fault_addr}
    function automatic logic [127:0] pack_res(input logic d, input logic o, input logic [1:0] e,
                                              input logic [31:0] s, input logic [31:0] r, input logic [31:0] f);
        return {28'h0, d, o, e, s, r, f};
    endfunction

    // Expected result of a fault class/syndrome, or a success
    function automatic logic [127:0] exp_res(input logic [1:0] e, input logic [31:0] s,
                                             input logic [31:0] r, input logic [31:0] ea);
        return (e == 2'd0) ? pack_res(1'b1, 1'b1, 2'd0, 32'h0, r, 32'h0)
                           : pack_res(1'b1, 1'b0, e, s, 32'h0, ea);
    endfunction

    task automatic one_req(input logic [31:0] ea, input logic [1:0] kind, input logic [2:0] cls,
                           input logic usr, input logic ir, input logic dr, input logic bg,
                           input logic [1:0] wst);
        logic fetch, store, on, key, walk;
        logic [31:0] sg, braddr, wraddr, sbit;
        logic [1:0]  ee;
        logic [31:0] es, er;
        string tag;
        fetch  = (kind == 2'd2);
        store  = (kind == 2'd1);
        on     = fetch ? ir : dr;
        sg     = segs[ea[31:28]];
        key    = usr ? sg[29] : sg[30];
        braddr = ea ^ 32'h5A5A_0000;
        wraddr = ~ea;
        sbit   = store ? 32'h0200_0000 : 32'h0;
        walk = 1'b0; ee = 2'd0; es = 32'h0; er = ea; tag = "R1";
        if (!on) begin
            tag = "R1";
        end else if (bg) begin
            tag = "R2"; er = braddr;
        end else if (sg[31]) begin
            if (sg[28:20] == 9'h07F) begin
                tag = "R4"; er = {sg[3:0], ea[27:0]};
            end else if (fetch) begin
                tag = "R5"; ee = 2'd1; es = 32'h1000_0000;
            end else if (cls == 3'd1) begin
                tag = "R5"; ee = 2'd3;
            end else if (cls == 3'd2) begin
                tag = "R5"; ee = 2'd2; es = 32'h0400_0000 + sbit;
            end else if (cls == 3'd4) begin
                tag = "R5"; ee = 2'd2; es = 32'h0410_0000 + sbit;
            end else if (cls == 3'd3) begin
                tag = "R5";
            end else begin
                tag = "R6";
                if ((store && !key) || (!store && key)) begin
                    ee = 2'd2; es = 32'h0800_0000 + sbit;
                end
            end
        end else if (fetch && sg[28]) begin
            tag = "R7"; ee = 2'd1; es = 32'h1000_0000;
        end else begin
            walk = 1'b1;
            if (wst == 2'd0) begin
                tag = "R9"; er = wraddr;
            end else if (wst == 2'd1) begin
                tag = "R9"; ee = fetch ? 2'd1 : 2'd2; es = 32'h4000_0000 + (fetch ? 32'h0 : sbit);
            end else begin
                tag = "R10"; ee = fetch ? 2'd1 : 2'd2; es = 32'h0800_0000 + (fetch ? 32'h0 : sbit);
            end
        end

        @(negedge clk);
        req_ea = ea; req_kind = kind; req_iclass = cls; priv_user = usr;
        irelo_en = ir; drelo_en = dr; blk_grant = bg; blk_raddr = braddr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (walk) begin
            check(walk_start_o && !done_o && walk_ea_o == ea && walk_seg_o == sg, "R8",
                  {30'h0, walk_start_o, done_o, walk_ea_o, walk_seg_o}, {30'h0, 2'b10, ea, sg});
            // Intruding real-mode request while the walk is pending
            req_ea = ~ea; req_kind = 2'd0; irelo_en = 1'b0; drelo_en = 1'b0; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check(!done_o && !walk_start_o, "R12", {126'h0, done_o, walk_start_o}, 128'h0);
            walk_done = 1'b1; walk_status = wst; walk_raddr = wraddr;
            @(negedge clk);
            walk_done = 1'b0;
        end
        check(pack_res(done_o, ok_o, exc_o, syndrome_o, raddr_o, fault_addr_o) == exp_res(ee, es, er, ea),
              {tag, " R11"}, pack_res(done_o, ok_o, exc_o, syndrome_o, raddr_o, fault_addr_o),
              exp_res(ee, es, er, ea));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !walk_start_o && exc_o == 2'd0 && syndrome_o == 0 && fault_addr_o == 0,
              "reset R11", {92'h0, done_o, walk_start_o, exc_o, syndrome_o}, 128'h0);
        // R3: load each segment register with a type chosen by its index
        for (int i = 0; i < 16; i++) begin
            logic [3:0] ii;
            ii = 4'(i);
            case (i % 4)
                0: segs[i] = {1'b0, ii[2], ii[3], 1'b0, 4'h0, 24'(i * 32'h111)};
                1: segs[i] = {1'b0, ii[2], ii[3], 1'b1, 4'h0, 24'(i * 32'h111)};
                2: segs[i] = {1'b1, ii[2], ii[3], 9'h07F, 16'h0, ii};
                default: segs[i] = {1'b1, ii[2], ii[3], 9'(9'h0A0 + i), 16'h0, ii};
            endcase
            @(negedge clk);
            seg_we = 1'b1; seg_idx = ii; seg_wdata = segs[i];
        end
        @(negedge clk);
        seg_we = 1'b0;
        n = 0;
        for (int s = 0; s < 16; s++)
            for (int k = 0; k < 3; k++)
                for (int c = 0; c < 5; c++)
                    for (int u = 0; u < 2; u++)
                        for (int m = 0; m < 8; m++) begin
                            logic [2:0] mm;
                            mm = 3'(m);
                            n++;
                            one_req({4'(s), 28'(n * 28'h0123457)}, 2'(k), (c == 0 && n[0]) ? 3'd6 : 3'(c),
                                    u[0], mm[0], mm[1], mm[2], 2'(n % 4));
                        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule